// File: doc/BRIEF.md
# Column-Pair End-of-Column Hit Controller

This block is the digital controller at the bottom of a pixel column pair. The pixels drive a shared hit line that is active whenever at least one pixel holds an unread hit. When the controller is idle and sees that line active, it stamps the event with the current value of its free-running bunch counter. It then sends a one-cycle token pulse up the column. While the token travels, each hit pixel it reaches presents its row number and a 3-bit amplitude for one cycle. The controller files every such hit in a hit buffer, and each hit carries the index of its event's timestamp slot. The scan ends when the token comes back from the last pixel.

Trigger requests arrive with a bunch-crossing timestamp on a valid/ready input. An accepted trigger is compared against every stored timestamp that is still inside the latency window. On a match, the controller streams out every buffered hit of that event and then frees both the hits and the timestamp slot. Events that grow older than the window without a trigger are freed automatically and never read out. Events that arrive while the timestamp slots are full, and hits that arrive while the hit buffer is full, are dropped. Either drop sets a sticky overflow flag.

Both streams follow valid/ready rules. A transfer happens on a rising clock edge where valid and ready are both high. The output holds `out_valid_o` and `out_data_o` unchanged while `out_ready_i` is low. The trigger input may be held pending as long as the source needs, and `trig_ready_o` is low while a scan or a readout is in progress.

Top module: `colpair_eoc`

## Requirements
- R1: After reset, `tok_out_o`, `out_valid_o` and `ovf_o` are 0, `trig_ready_o` is 1, and `bx_o` is 0. `bx_o` then increases by one every clock.
- R2: A clock edge that finds the controller idle, `fast_or_i` high and a free timestamp slot records the `bx_o` value sampled at that edge as the event timestamp. `tok_out_o` is high for exactly the following cycle. `fast_or_i` has no effect while a scan is running.
- R3: During a scan, every edge with `pix_valid_i` high captures `pix_row_i` and `pix_amp_i` as one hit of the current event. An edge with `tok_ret_i` high ends the scan, and a `fast_or_i` still high on a later edge starts a new event.
- R4: An accepted trigger whose timestamp equals a stored, unexpired event timestamp makes the block emit each hit of that event exactly once. Each hit is one word {timestamp[18:11], row[10:3], amplitude[2:0]}, and hits captured into an empty buffer leave in capture order.
- R5: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o` stays high and `out_data_o` stays unchanged.
- R6: An accepted trigger that matches no stored timestamp produces no output word and leaves the stored hits available for a later matching trigger.
- R7: With all 8 timestamp slots in use, an event start is dropped: no token pulse follows, and `ovf_o` goes high and stays high until reset.
- R8: A hit captured while the buffer holds 24 hits is dropped and sets `ovf_o`. The 24 stored hits remain readable.
- R9: An event whose age (`bx_o` minus its timestamp, modulo 256) exceeds `LAT` can no longer be read out. Its timestamp slot is freed for new events.
- R10: `trig_ready_o` is low while a scan or a readout is in progress.
- R11: A trigger reads out only the hits of the matching event. Hits of other events stay stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fast_or_i | input | 1 | Wired hit line from the column pair |
| tok_out_o | output | 1 | One-cycle token launch into the column |
| pix_valid_i | input | 1 | Token-holding pixel presents a hit this cycle |
| pix_row_i | input | 8 | Row address of the presenting pixel |
| pix_amp_i | input | 3 | Amplitude code of the presenting pixel |
| tok_ret_i | input | 1 | Token came back from the last pixel |
| trig_valid_i | input | 1 | Trigger request valid |
| trig_ts_i | input | 8 | Trigger timestamp |
| trig_ready_o | output | 1 | Trigger request can be accepted |
| out_valid_o | output | 1 | Readout word valid |
| out_ready_i | input | 1 | Readout sink ready |
| out_data_o | output | 19 | Readout word {timestamp, row, amplitude} |
| ovf_o | output | 1 | Sticky drop flag |
| bx_o | output | 8 | Free-running bunch counter |

## Verification
The bench first runs a single event with several hits and then two interleaved events, triggering the later one first. Together these show whether a trigger selects hits by event index rather than by buffer position. A trigger with an off-by-one timestamp followed by a correct one separates "no match" from "matched but lost". A stalled sink shows whether the output word holds. A Fast-OR held high across the token return shows that the line is ignored during a scan and honoured afterwards. Filling the timestamp slots, overfilling the hit buffer, and letting an event age past the window check the three ways data is refused or discarded. The slot reuse after expiry shows that freeing is real, not just a blocked readout.

// File: rtl/eoc_pkg.sv
package eoc_pkg;
  typedef enum logic {SC_IDLE, SC_SCAN} scan_st_t;
endpackage

// File: rtl/eoc_ts_store.sv
module eoc_ts_store #(
  parameter int TS_W  = 8,
  parameter int DEPTH = 8,
  parameter int LAT   = 48,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TS_W-1:0]  bx_i,
  input  logic             alloc_i,
  input  logic             free_i,
  input  logic [IDX_W-1:0] free_idx_i,
  input  logic [TS_W-1:0]  trig_ts_i,
  input  logic             scan_busy_i,
  input  logic [IDX_W-1:0] scan_idx_i,
  input  logic             rd_busy_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             full_o,
  output logic [IDX_W-1:0] alloc_idx_o,
  output logic             match_o,
  output logic [IDX_W-1:0] match_idx_o,
  output logic [TS_W-1:0]  rd_ts_o,
  output logic             purge_o,
  output logic [IDX_W-1:0] purge_idx_o
);
  logic [DEPTH-1:0] vld_q;
  logic [TS_W-1:0]  ts_q [DEPTH];
  logic [DEPTH-1:0] fresh_w;
  logic [DEPTH-1:0] pinned_w;
  logic             a_found;

  // age is taken modulo 2^TS_W; an entry is fresh while its age is within LAT
  for (genvar g = 0; g < DEPTH; g++) begin : g_age
    logic [TS_W-1:0] age_w;
    assign age_w       = bx_i - ts_q[g];
    assign fresh_w[g]  = (age_w <= TS_W'(LAT));
    assign pinned_w[g] = (scan_busy_i && scan_idx_i == IDX_W'(g)) ||
                         (rd_busy_i && rd_idx_i == IDX_W'(g));
  end

  assign full_o  = &vld_q;
  assign rd_ts_o = ts_q[rd_idx_i];

  always_comb begin
    alloc_idx_o = '0;
    a_found     = 1'b0;
    match_o     = 1'b0;
    match_idx_o = '0;
    purge_o     = 1'b0;
    purge_idx_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!vld_q[i] && !a_found) begin
        alloc_idx_o = IDX_W'(i);
        a_found     = 1'b1;
      end
      if (vld_q[i] && fresh_w[i] && ts_q[i] == trig_ts_i && !match_o) begin
        match_idx_o = IDX_W'(i);
        match_o     = 1'b1;
      end
      if (vld_q[i] && !fresh_w[i] && !pinned_w[i] && !purge_o) begin
        purge_idx_o = IDX_W'(i);
        purge_o     = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      if (alloc_i) vld_q[alloc_idx_o] <= 1'b1;
      if (free_i)  vld_q[free_idx_i]  <= 1'b0;
      if (purge_o) vld_q[purge_idx_o] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_i) ts_q[alloc_idx_o] <= bx_i;
  end
endmodule

// File: rtl/eoc_hit_buf.sv
module eoc_hit_buf #(
  parameter int DEPTH  = 24,
  parameter int TIDX_W = 3,
  parameter int ROW_W  = 8,
  parameter int AMP_W  = 3,
  localparam int SLOT_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [TIDX_W-1:0] wr_tidx_i,
  input  logic [ROW_W-1:0]  wr_row_i,
  input  logic [AMP_W-1:0]  wr_amp_i,
  output logic              full_o,
  input  logic              sel_en_i,
  input  logic [TIDX_W-1:0] sel_tidx_i,
  output logic              sel_valid_o,
  output logic [ROW_W-1:0]  sel_row_o,
  output logic [AMP_W-1:0]  sel_amp_o,
  input  logic              pop_i,
  input  logic              purge_i,
  input  logic [TIDX_W-1:0] purge_tidx_i
);
  logic [DEPTH-1:0]  vld_q;
  logic [TIDX_W-1:0] tidx_q [DEPTH];
  logic [ROW_W-1:0]  row_q  [DEPTH];
  logic [AMP_W-1:0]  amp_q  [DEPTH];
  logic [SLOT_W-1:0] wr_slot;
  logic [SLOT_W-1:0] sel_slot;
  logic              w_found;
  logic              do_wr;

  assign full_o    = &vld_q;
  assign do_wr     = wr_i && !full_o;
  assign sel_row_o = row_q[sel_slot];
  assign sel_amp_o = amp_q[sel_slot];

  // lowest free slot takes the next hit; lowest slot of the selected event leaves first
  always_comb begin
    wr_slot     = '0;
    w_found     = 1'b0;
    sel_slot    = '0;
    sel_valid_o = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!vld_q[i] && !w_found) begin
        wr_slot = SLOT_W'(i);
        w_found = 1'b1;
      end
      if (sel_en_i && vld_q[i] && tidx_q[i] == sel_tidx_i && !sel_valid_o) begin
        sel_slot    = SLOT_W'(i);
        sel_valid_o = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      if (do_wr) vld_q[wr_slot] <= 1'b1;
      if (pop_i && sel_valid_o) vld_q[sel_slot] <= 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        if (purge_i && vld_q[i] && tidx_q[i] == purge_tidx_i) vld_q[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) begin
      tidx_q[wr_slot] <= wr_tidx_i;
      row_q[wr_slot]  <= wr_row_i;
      amp_q[wr_slot]  <= wr_amp_i;
    end
  end
endmodule

// File: rtl/colpair_eoc.sv
module colpair_eoc #(
  parameter int NROWS     = 160,
  parameter int AMP_W     = 3,
  parameter int TS_W      = 8,
  parameter int TS_DEPTH  = 8,
  parameter int HIT_DEPTH = 24,
  parameter int LAT       = 48,
  localparam int ROW_W  = $clog2(NROWS),
  localparam int WORD_W = TS_W + ROW_W + AMP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fast_or_i,
  output logic              tok_out_o,
  input  logic              pix_valid_i,
  input  logic [ROW_W-1:0]  pix_row_i,
  input  logic [AMP_W-1:0]  pix_amp_i,
  input  logic              tok_ret_i,
  input  logic              trig_valid_i,
  input  logic [TS_W-1:0]   trig_ts_i,
  output logic              trig_ready_o,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [WORD_W-1:0] out_data_o,
  output logic              ovf_o,
  output logic [TS_W-1:0]   bx_o
);
  import eoc_pkg::*;
  localparam int TIDX_W = $clog2(TS_DEPTH);

  logic [TS_W-1:0]   bx_q;
  scan_st_t          scan_q;
  logic [TIDX_W-1:0] scan_idx_q;
  logic              tok_q;
  logic              ovf_q;
  logic              rd_busy_q;
  logic [TIDX_W-1:0] rd_idx_q;

  logic              ts_full, ts_match, ts_purge;
  logic [TIDX_W-1:0] alloc_idx, match_idx, purge_idx;
  logic [TS_W-1:0]   rd_ts;
  logic              hit_full, sel_valid;
  logic [ROW_W-1:0]  sel_row;
  logic [AMP_W-1:0]  sel_amp;

  logic scan_idle, start, ev_drop, cap, hit_drop, trig_acc, pop, rd_done;

  assign scan_idle = (scan_q == SC_IDLE);
  assign start     = scan_idle && fast_or_i && !ts_full;
  assign ev_drop   = scan_idle && fast_or_i && ts_full;
  assign cap       = !scan_idle && pix_valid_i;
  assign hit_drop  = cap && hit_full;
  assign trig_ready_o = scan_idle && !rd_busy_q;
  assign trig_acc  = trig_valid_i && trig_ready_o;
  assign out_valid_o = rd_busy_q && sel_valid;
  assign pop       = out_valid_o && out_ready_i;
  assign rd_done   = rd_busy_q && !sel_valid;
  assign out_data_o = {rd_ts, sel_row, sel_amp};
  assign tok_out_o = tok_q;
  assign ovf_o     = ovf_q;
  assign bx_o      = bx_q;

  eoc_ts_store #(.TS_W(TS_W), .DEPTH(TS_DEPTH), .LAT(LAT)) ts_i (
    .clk(clk), .rst_n(rst_n), .bx_i(bx_q),
    .alloc_i(start), .free_i(rd_done), .free_idx_i(rd_idx_q),
    .trig_ts_i(trig_ts_i),
    .scan_busy_i(!scan_idle), .scan_idx_i(scan_idx_q),
    .rd_busy_i(rd_busy_q), .rd_idx_i(rd_idx_q),
    .full_o(ts_full), .alloc_idx_o(alloc_idx),
    .match_o(ts_match), .match_idx_o(match_idx),
    .rd_ts_o(rd_ts), .purge_o(ts_purge), .purge_idx_o(purge_idx)
  );

  eoc_hit_buf #(.DEPTH(HIT_DEPTH), .TIDX_W(TIDX_W), .ROW_W(ROW_W), .AMP_W(AMP_W)) hb_i (
    .clk(clk), .rst_n(rst_n),
    .wr_i(cap), .wr_tidx_i(scan_idx_q), .wr_row_i(pix_row_i), .wr_amp_i(pix_amp_i),
    .full_o(hit_full),
    .sel_en_i(rd_busy_q), .sel_tidx_i(rd_idx_q),
    .sel_valid_o(sel_valid), .sel_row_o(sel_row), .sel_amp_o(sel_amp),
    .pop_i(pop), .purge_i(ts_purge), .purge_tidx_i(purge_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bx_q       <= '0;
      scan_q     <= SC_IDLE;
      scan_idx_q <= '0;
      tok_q      <= 1'b0;
      ovf_q      <= 1'b0;
      rd_busy_q  <= 1'b0;
      rd_idx_q   <= '0;
    end else begin
      bx_q  <= bx_q + 1'b1;
      tok_q <= start;
      ovf_q <= ovf_q | ev_drop | hit_drop;
      if (start) begin
        scan_q     <= SC_SCAN;
        scan_idx_q <= alloc_idx;
      end else if (!scan_idle && tok_ret_i) begin
        scan_q <= SC_IDLE;
      end
      if (trig_acc && ts_match) begin
        rd_busy_q <= 1'b1;
        rd_idx_q  <= match_idx;
      end else if (rd_done) begin
        rd_busy_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/eoc_checker.sv
module eoc_checker #(
  parameter int WORD_W = 19,
  parameter int TS_W   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tok_out,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data,
  input logic              trig_ready,
  input logic              ovf,
  input logic [TS_W-1:0]   bx,
  input logic              ts_full,
  input logic              scan_idle
);
  AST_TOKEN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tok_out |=> !tok_out); // R2
  AST_BX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> bx == $past(bx) + 1'b1); // R1
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R5
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf); // R7
  AST_FULL_NO_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
    scan_idle && ts_full |=> !tok_out); // R7
  AST_TRIG_BLOCK_RD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !trig_ready); // R10
  AST_TRIG_BLOCK_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
    tok_out |-> !trig_ready); // R10
endmodule

bind colpair_eoc eoc_checker #(.WORD_W(WORD_W), .TS_W(TS_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tok_out(tok_out_o), .out_valid(out_valid_o),
  .out_ready(out_ready_i), .out_data(out_data_o), .trig_ready(trig_ready_o),
  .ovf(ovf_o), .bx(bx_o), .ts_full(ts_full), .scan_idle(scan_idle)
);

// File: tb/colpair_eoc_tb_top.sv
module colpair_eoc_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fast_or, tok_out, pix_valid, tok_ret;
  logic [7:0]  pix_row;
  logic [2:0]  pix_amp;
  logic        trig_valid, trig_ready, out_valid, out_ready, ovf;
  logic [7:0]  trig_ts, bx;
  logic [18:0] out_data;

  int checks = 0;
  int errors = 0;
  logic [18:0] got [32];
  int got_n;

  always #4 clk = ~clk;

  colpair_eoc dut_i (
    .clk(clk), .rst_n(rst_n), .fast_or_i(fast_or), .tok_out_o(tok_out),
    .pix_valid_i(pix_valid), .pix_row_i(pix_row), .pix_amp_i(pix_amp),
    .tok_ret_i(tok_ret), .trig_valid_i(trig_valid), .trig_ts_i(trig_ts),
    .trig_ready_o(trig_ready), .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_data_o(out_data), .ovf_o(ovf), .bx_o(bx)
  );

  function automatic logic [2:0] amp_of(input int r);
    return 3'((r * 5 + 2) & 7);
  endfunction

  function automatic logic [18:0] word_of(input logic [7:0] t, input int r);
    return {t, 8'(r), amp_of(r)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; fast_or = 0; pix_valid = 0; tok_ret = 0; pix_row = 0; pix_amp = 0;
    trig_valid = 0; trig_ts = 0; out_ready = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_event(input int n, input int row0, output logic [7:0] ts);
    ts = bx;
    fast_or = 1;
    @(negedge clk);
    fast_or = 0;
    chk(tok_out == 1'b1, "R2 token after hit line", 32'(tok_out), 1);
    for (int k = 0; k < n; k++) begin
      pix_valid = 1; pix_row = 8'(row0 + k); pix_amp = amp_of(row0 + k);
      @(negedge clk);
    end
    pix_valid = 0; tok_ret = 1;
    @(negedge clk);
    tok_ret = 0;
  endtask

  task automatic fire_trig(input logic [7:0] t);
    while (!trig_ready) @(negedge clk);
    trig_valid = 1; trig_ts = t;
    @(negedge clk);
    trig_valid = 0;
  endtask

  task automatic collect(input int cycles);
    got_n = 0;
    out_ready = 1;
    for (int c = 0; c < cycles; c++) begin
      if (out_valid && got_n < 32) begin
        got[got_n] = out_data;
        got_n++;
      end
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk(tok_out == 0, "R1 tok_out", 32'(tok_out), 0);
    chk(out_valid == 0, "R1 out_valid", 32'(out_valid), 0);
    chk(ovf == 0, "R1 ovf", 32'(ovf), 0);
    chk(trig_ready == 1, "R1 trig_ready", 32'(trig_ready), 1);
    chk(bx == 0, "R1 bx", 32'(bx), 0);
    @(negedge clk);
    chk(bx == 1, "R1 bx counts", 32'(bx), 1);
  endtask

  task automatic t_basic();
    logic [7:0] ts;
    do_reset();
    run_event(3, 10, ts);
    fire_trig(ts);
    collect(12);
    chk(got_n == 3, "R4 word count", 32'(got_n), 3);
    for (int k = 0; k < 3; k++)
      chk(got[k] == word_of(ts, 10 + k), "R3 R4 word content", 32'(got[k]), 32'(word_of(ts, 10 + k)));
    fire_trig(ts);
    collect(8);
    chk(got_n == 0, "R4 hits read only once", 32'(got_n), 0);
  endtask

  task automatic t_backpressure();
    logic [7:0]  ts;
    logic [18:0] d0;
    do_reset();
    run_event(3, 20, ts);
    out_ready = 0;
    fire_trig(ts);
    d0 = out_data;
    chk(out_valid == 1 && d0 == word_of(ts, 20), "R5 first word offered", 32'(d0), 32'(word_of(ts, 20)));
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(out_valid == 1 && out_data == d0, "R5 word held while stalled", 32'(out_data), 32'(d0));
    end
    collect(10);
    chk(got_n == 3 && got[0] == d0 && got[2] == word_of(ts, 22), "R5 stream after stall",
        32'(got_n), 3);
  endtask

  task automatic t_nomatch();
    logic [7:0] ts;
    do_reset();
    run_event(2, 40, ts);
    fire_trig(ts + 8'd1);
    collect(8);
    chk(got_n == 0, "R6 no output on mismatch", 32'(got_n), 0);
    fire_trig(ts);
    collect(8);
    chk(got_n == 2 && got[1] == word_of(ts, 41), "R6 hits kept for later trigger", 32'(got_n), 2);
  endtask

  task automatic t_two_events();
    logic [7:0] ta, tb;
    do_reset();
    run_event(2, 50, ta);
    run_event(3, 60, tb);
    chk(ta != tb, "R2 distinct timestamps", 32'(ta), 32'(tb) + 1);
    fire_trig(tb);
    collect(10);
    chk(got_n == 3 && got[0] == word_of(tb, 60) && got[2] == word_of(tb, 62),
        "R11 only later event read", 32'(got_n), 3);
    fire_trig(ta);
    collect(10);
    chk(got_n == 2 && got[0] == word_of(ta, 50) && got[1] == word_of(ta, 51),
        "R11 earlier event intact", 32'(got_n), 2);
  endtask

  task automatic t_pending();
    logic [7:0] t0, t1;
    do_reset();
    t0 = bx;
    fast_or = 1;
    @(negedge clk);
    chk(tok_out == 1, "R2 token launched", 32'(tok_out), 1);
    chk(trig_ready == 0, "R10 no trigger during scan", 32'(trig_ready), 0);
    pix_valid = 1; pix_row = 8'd70; pix_amp = amp_of(70);
    @(negedge clk);
    chk(tok_out == 0, "R2 hit line ignored during scan", 32'(tok_out), 0);
    pix_valid = 0; tok_ret = 1;
    @(negedge clk);
    tok_ret = 0;
    t1 = bx;
    @(negedge clk);
    fast_or = 0;
    chk(tok_out == 1, "R3 new scan for pending hit line", 32'(tok_out), 1);
    tok_ret = 1;
    @(negedge clk);
    tok_ret = 0;
    fire_trig(t0);
    collect(8);
    chk(got_n == 1 && got[0] == word_of(t0, 70), "R3 first scan hit", 32'(got_n), 1);
    fire_trig(t1);
    collect(6);
    chk(got_n == 0, "R11 second event has no hits", 32'(got_n), 0);
  endtask

  task automatic t_ts_full();
    logic [7:0] ts;
    do_reset();
    for (int e = 0; e < 8; e++) run_event(0, 0, ts);
    chk(ovf == 0, "R7 no overflow at 8 events", 32'(ovf), 0);
    fast_or = 1;
    @(negedge clk);
    fast_or = 0;
    chk(tok_out == 0, "R7 ninth event no token", 32'(tok_out), 0);
    chk(ovf == 1, "R7 overflow set", 32'(ovf), 1);
    repeat (4) @(negedge clk);
    chk(ovf == 1, "R7 overflow sticky", 32'(ovf), 1);
  endtask

  task automatic t_hit_full();
    logic [7:0] ts;
    do_reset();
    run_event(26, 0, ts);
    chk(ovf == 1, "R8 overflow on full buffer", 32'(ovf), 1);
    fire_trig(ts);
    collect(40);
    chk(got_n == 24, "R8 24 hits kept", 32'(got_n), 24);
    chk(got[23] == word_of(ts, 23), "R8 last kept hit", 32'(got[23]), 32'(word_of(ts, 23)));
  endtask

  task automatic t_stale();
    logic [7:0] ts, tn;
    do_reset();
    run_event(1, 80, ts);
    repeat (60) @(negedge clk);
    fire_trig(ts);
    collect(8);
    chk(got_n == 0, "R9 expired event not read", 32'(got_n), 0);
    for (int e = 0; e < 8; e++) run_event(0, 0, tn);
    chk(ovf == 0, "R9 expired slot reused", 32'(ovf), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_backpressure();
    t_nomatch();
    t_two_events();
    t_pending();
    t_ts_full();
    t_hit_full();
    t_stale();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule